// File: doc/BRIEF.md
# External Interrupt Request Latch

This block gathers external interrupt requests for a small 8-bit microcontroller core. There is one dedicated interrupt pin, which is active low. There are also four general-purpose port pins, which are active high and can be switched in as extra interrupt inputs. Each pin passes through a two-flop synchronizer. The enabled port pins and the inverted dedicated pin are ORed into one request source, and an edge detector watches that source. A single static sensitivity bit picks between two modes. In edge mode, only the transition into the active state is recognised. In edge-plus-level mode, the request is also held for as long as the source stays active, so several open-drain sources can share one line.

The request latch stays set until the CPU acknowledges it during its interrupt sequence. If a fresh request arrives during the service routine, it is latched again. The CPU is offered the interrupt only at an instruction boundary, and only while its interrupt mask bit is clear. Masking blocks the interrupt but does not disturb the latch. The reset input is asynchronous and active low, and it is expected to be released synchronously to `clk`.

Top module: `ext_irq_latch`

## Requirements
- R1: While reset is asserted and after it is released with idle pins, `irq_pending` and `irq_take` are 0.
- R2: A 1-to-0 transition on `irq_pin_n` sets `irq_pending` on the third rising clock edge after the pin changes, and not on the second. The latch then stays set after the pin returns high, until an acknowledge.
- R3: With `cfg_level` = 0 (edge only), a pin that is still held active after an acknowledge does not set the latch again.
- R4: With `cfg_level` = 1, an active level on any enabled source sets the latch. An acknowledge given while the level is still active leaves `irq_pending` at 1.
- R5: With `cfg_port_en` = 1, a 0-to-1 transition on any bit of `port_pin` sets the latch with the same three-edge timing as R2.
- R6: With `cfg_port_en` = 0, activity on `port_pin` never sets the latch. The enable is registered and reads as 0 out of reset.
- R7: In level mode, with several sources active at once, the latch stays set across acknowledges until the last source goes inactive. An acknowledge after that clears it.
- R8: `irq_take` = `irq_pending` AND `insn_done` AND NOT `cpu_mask`, in the same cycle. `cpu_mask` does not change `irq_pending`.
- R9: A one-cycle `irq_ack` clears `irq_pending` at that clock edge, unless a new edge (or, in level mode, an active level) is seen in the same cycle. In that case the latch stays set.
- R10: A request latched after the acknowledge while `cpu_mask` = 1 asserts `irq_take` at the first instruction boundary with `cpu_mask` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_port_en | input | 1 | Static: port pins act as interrupt inputs |
| cfg_level | input | 1 | Static: 0 edge only, 1 edge plus level |
| irq_pin_n | input | 1 | Dedicated interrupt pin, active low, asynchronous |
| port_pin | input | NPORT (4) | Port pins, active high, asynchronous |
| cpu_mask | input | 1 | CPU interrupt mask bit, 1 blocks |
| insn_done | input | 1 | Strobe at the instruction boundary |
| irq_ack | input | 1 | One-cycle pulse from the CPU interrupt sequence |
| irq_pending | output | 1 | Latched external request |
| irq_take | output | 1 | Interrupt to be taken at this boundary |

## Verification
Three latency rules govern the checks:
- A pin change reaches `irq_pending` at the third rising edge after it is applied. The bench therefore checks that the latch is still clear after two edges and set after three.
- An acknowledge takes effect at the single edge where it is sampled, so results are read one edge later.
- `irq_take` is combinational, so it is read a short delay after its inputs change, within the same cycle.

All inputs are driven on falling edges and all outputs are read on falling edges or just after a drive. No reading ever coincides with a rising edge.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  typedef enum logic {
    SENS_EDGE       = 1'b0,
    SENS_EDGE_LEVEL = 1'b1
  } sens_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= RST_VAL;
    else        stage_q[0] <= d;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= RST_VAL;
      else        stage_q[g] <= stage_q[g-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/irq_src_detect.sv
module irq_src_detect #(
  parameter int NPORT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_port_en,
  input  logic             ded_n_s,
  input  logic [NPORT-1:0] port_s,
  output logic             src_act,
  output logic             src_edge
);
  logic en_q, en_d;
  logic prev_q, prev_d;
  logic port_any;

  // next state
  always_comb begin
    en_d     = cfg_port_en;
    port_any = en_q & (|port_s);
    src_act  = ~ded_n_s | port_any;
    src_edge = src_act & ~prev_q;
    prev_d   = src_act;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      prev_q <= prev_d;
    end
  end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_latch_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_level,
  input  logic src_act,
  input  logic src_edge,
  input  logic irq_ack,
  output logic pend_q
);
  sens_e mode;
  logic  set_req, pend_d, pend_en;

  // next state
  always_comb begin
    mode    = sens_e'(cfg_level);
    set_req = src_edge | ((mode == SENS_EDGE_LEVEL) & src_act);
    pend_d  = set_req | (pend_q & ~irq_ack);
    pend_en = set_req | irq_ack;
  end

  // register with clock enable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch #(
  parameter int NPORT       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_port_en,
  input  logic             cfg_level,
  input  logic             irq_pin_n,
  input  logic [NPORT-1:0] port_pin,
  input  logic             cpu_mask,
  input  logic             insn_done,
  input  logic             irq_ack,
  output logic             irq_pending,
  output logic             irq_take
);
  localparam logic [NPORT-1:0] PORT_IDLE = '0;
  localparam logic [0:0]       DED_IDLE  = 1'b1;

  logic             ded_n_s;
  logic [NPORT-1:0] port_s;
  logic             src_act, src_edge;

  irq_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(DED_IDLE)) u_sync_ded (
    .clk(clk), .rst_n(rst_n), .d(irq_pin_n), .q(ded_n_s)
  );

  irq_sync #(.W(NPORT), .STAGES(SYNC_STAGES), .RST_VAL(PORT_IDLE)) u_sync_port (
    .clk(clk), .rst_n(rst_n), .d(port_pin), .q(port_s)
  );

  irq_src_detect #(.NPORT(NPORT)) u_src (
    .clk(clk), .rst_n(rst_n), .cfg_port_en(cfg_port_en),
    .ded_n_s(ded_n_s), .port_s(port_s),
    .src_act(src_act), .src_edge(src_edge)
  );

  irq_req_latch u_latch (
    .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level),
    .src_act(src_act), .src_edge(src_edge),
    .irq_ack(irq_ack), .pend_q(irq_pending)
  );

  assign irq_take = irq_pending & insn_done & ~cpu_mask;
endmodule

// File: rtl/ext_irq_latch_chk.sv
module ext_irq_latch_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_level,
  input logic irq_ack,
  input logic cpu_mask,
  input logic insn_done,
  input logic irq_pending,
  input logic irq_take,
  input logic src_act,
  input logic src_edge
);
  // R8
  mask_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_mask || !insn_done) |-> !irq_take);

  // R8
  take_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |-> irq_pending);

  // R2
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending && !irq_ack) |=> irq_pending);

  // R2
  set_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pending) |-> $past(src_edge || (cfg_level && src_act)));

  // R4
  level_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_level && src_act) |=> irq_pending);

  // R9
  ack_edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && src_edge) |=> irq_pending);

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !src_edge && !(cfg_level && src_act)) |=> !irq_pending);
endmodule

bind ext_irq_latch ext_irq_latch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_level(cfg_level), .irq_ack(irq_ack),
  .cpu_mask(cpu_mask), .insn_done(insn_done), .irq_pending(irq_pending),
  .irq_take(irq_take), .src_act(src_act), .src_edge(src_edge)
);

// File: tb/ext_irq_latch_test.sv
`timescale 1ns/1ps
module ext_irq_latch_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_port_en, cfg_level, irq_pin_n, cpu_mask, insn_done, irq_ack;
  logic [3:0] port_pin;
  logic       irq_pending, irq_take;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_latch uut (
    .clk(clk), .rst_n(rst_n), .cfg_port_en(cfg_port_en), .cfg_level(cfg_level),
    .irq_pin_n(irq_pin_n), .port_pin(port_pin), .cpu_mask(cpu_mask),
    .insn_done(insn_done), .irq_ack(irq_ack),
    .irq_pending(irq_pending), .irq_take(irq_take)
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_src(input int s, input logic on);
    if (s == 0) irq_pin_n = ~on;
    else        port_pin[s-1] = on;
  endtask

  task automatic ack_pulse();
    irq_ack = 1'b1;
    tick(1);
    irq_ack = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all reqs): finished %0b expected %0b", 1'b0, 1'b1);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_port_en = 1'b1; cfg_level = 1'b0; irq_pin_n = 1'b1;
    port_pin = 4'h0; cpu_mask = 1'b0; insn_done = 1'b1; irq_ack = 1'b0;
    tick(3);
    chk(irq_pending, 1'b0, "R1 pending in reset");
    chk(irq_take, 1'b0, "R1 take in reset");
    rst_n = 1'b1;
    tick(4);
    chk(irq_pending, 1'b0, "R1 pending after reset");
    chk(irq_take, 1'b0, "R1 take after reset");
    insn_done = 1'b0;

    // sweep: mode x port enable x source
    for (int lv = 0; lv < 2; lv++) begin
      for (int en = 0; en < 2; en++) begin
        for (int s = 0; s < 5; s++) begin
          logic  exp;
          string tg_set, tg_hold;
          exp     = (s == 0) || (en == 1);
          tg_set  = (s == 0) ? "R2" : ((en == 1) ? "R5" : "R6");
          tg_hold = (lv == 1) ? ((s == 0) ? "R4" : "R7") : "R3";
          cfg_level = lv[0]; cfg_port_en = en[0];
          irq_pin_n = 1'b1; port_pin = 4'h0;
          tick(4);
          ack_pulse();
          chk(irq_pending, 1'b0, "R9 clear before case");
          set_src(s, 1'b1);
          tick(2);
          chk(irq_pending, 1'b0, {tg_set, " not yet at edge 2"});
          tick(1);
          chk(irq_pending, exp, {tg_set, " set at edge 3"});
          tick(3);
          ack_pulse();
          chk(irq_pending, exp && (lv == 1), {tg_hold, " ack while active"});
          set_src(s, 1'b0);
          tick(3);
          chk(irq_pending, exp && (lv == 1), {tg_hold, " after release"});
          ack_pulse();
          chk(irq_pending, 1'b0, "R9 ack clears");
        end
      end
    end

    // R7 wire-OR in level mode
    cfg_level = 1'b1; cfg_port_en = 1'b1;
    irq_pin_n = 1'b0; port_pin = 4'b0101;
    tick(3);
    chk(irq_pending, 1'b1, "R7 three sources");
    port_pin[0] = 1'b0; tick(3); ack_pulse();
    chk(irq_pending, 1'b1, "R7 two sources left");
    irq_pin_n = 1'b1; tick(3); ack_pulse();
    chk(irq_pending, 1'b1, "R7 one source left");
    port_pin[2] = 1'b0; tick(3); ack_pulse();
    chk(irq_pending, 1'b0, "R7 all released");

    // R8 take gating sweep, edge mode
    cfg_level = 1'b0;
    for (int p = 0; p < 2; p++) begin
      if (p == 1) begin
        irq_pin_n = 1'b0; tick(3); irq_pin_n = 1'b1; tick(3);
      end
      for (int m = 0; m < 2; m++) begin
        for (int d = 0; d < 2; d++) begin
          cpu_mask = m[0]; insn_done = d[0];
          #1;
          chk(irq_take, (p == 1) && (d == 1) && (m == 0), "R8 take");
          tick(1);
          chk(irq_pending, p[0], "R8 mask keeps latch");
        end
      end
      cpu_mask = 1'b0; insn_done = 1'b0;
      ack_pulse();
    end

    // R9 ack and new edge in the same cycle
    irq_pin_n = 1'b0; tick(3); irq_pin_n = 1'b1; tick(3);
    chk(irq_pending, 1'b1, "R9 pre-set");
    irq_pin_n = 1'b0; tick(2);
    irq_ack = 1'b1; tick(1); irq_ack = 1'b0;
    chk(irq_pending, 1'b1, "R9 edge beats ack");
    irq_pin_n = 1'b1; tick(3); ack_pulse();
    chk(irq_pending, 1'b0, "R9 later ack clears");

    // R10 request during handler
    irq_pin_n = 1'b0; tick(3); irq_pin_n = 1'b1;
    insn_done = 1'b1; #1;
    chk(irq_take, 1'b1, "R10 first take");
    tick(1);
    insn_done = 1'b0; cpu_mask = 1'b1;
    ack_pulse();
    chk(irq_pending, 1'b0, "R10 acked");
    tick(2);
    irq_pin_n = 1'b0; tick(3); irq_pin_n = 1'b1;
    chk(irq_pending, 1'b1, "R10 latched in handler");
    insn_done = 1'b1; #1;
    chk(irq_take, 1'b0, "R10 masked in handler");
    tick(1);
    cpu_mask = 1'b0; #1;
    chk(irq_take, 1'b1, "R10 taken after unmask");
    tick(1);
    insn_done = 1'b0;
    ack_pulse();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule